// File: doc/BRIEF.md
# Turbo-Pin Reference Code Selector

This block picks the reference fine-tune code for four regulator channels (memory supply, termination supply, analog supply and link supply). Each channel has an 8-bit setting byte from the register bank holding two 4-bit tune values. A turbo input pin decides which of the two values is used. Switching in one direction takes effect at once; switching in the other waits a fixed settling delay. A polarity bit picks which direction is slow. A manual mode ignores the pin and always uses the upper value. A master tune-enable falls back to a fixed default code. An optional reduce mode maps the smallest tune values to four voltages below the normal range.

The block drives a 5-bit code per channel toward the reference DAC. It also gives the same value in millivolts so that it can be checked. The pin is synchronized and filtered before use. Only the digital code path is built here.

Top module: `turbo_ref_select`

## Requirements
- R1: A 5-bit output code c stands for 660 + 20*c mV, and ref_mv carries that value. A 4-bit tune value n gives code n+4, so 0 is 740 mV and 15 is 1040 mV. Output codes never exceed 19.
- R2: With mode_manual=1, every channel uses the upper nibble of its byte (bits [8i+7:8i+4] for channel i), whatever the turbo pin does.
- R3: With mode_manual=0 and turbo_en=0, every channel outputs code 7 (800 mV). This holds even when decrease_en=1.
- R4: With decrease_en=1, a selected tune value whose bits [3:2] are 00 maps its bits [1:0] = 0,1,2,3 to 720, 700, 680 and 660 mV. Any other selected value follows R1.
- R5: With mode_manual=0, turbo_en=1 and turbo_inv=0, the filtered pin picks a nibble: high selects the upper nibble and low selects the lower one. A rising pin reaches the outputs STABLE_CYC+3 cycles after the first clock edge that samples it. A falling pin reaches them STABLE_CYC+DELAY_CYC+2 cycles after that edge.
- R6: With turbo_inv=1 the two timings swap. A falling pin is applied after STABLE_CYC+3 cycles and a rising pin after STABLE_CYC+DELAY_CYC+2 cycles.
- R7: If the filtered pin returns to its applied level while a delayed change is pending, the pending change is dropped.
- R8: A pin level held for fewer than STABLE_CYC cycles has no effect on the outputs.
- R9: During and right after reset, every channel outputs code 7 (800 mV), and the applied turbo level is low.
- R10: A change of mode_manual, turbo_en, decrease_en or chan_cfg reaches the outputs on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| turbo_pin | input | 1 | Asynchronous turbo select pin |
| mode_manual | input | 1 | 0 = pin-driven turbo mode, 1 = manual (upper nibble) |
| turbo_en | input | 1 | Enables tuning in turbo mode |
| turbo_inv | input | 1 | 0 = falling edge delayed, 1 = rising edge delayed |
| decrease_en | input | 1 | Enables the reduced-voltage mapping |
| chan_cfg | input | 8*NCH | Per-channel byte, upper nibble = high value |
| ref_code | output | 5*NCH | Per-channel reference code |
| ref_mv | output | 11*NCH | Per-channel reference in millivolts |

## Verification
Setting changes are registered once, so the bench samples one clock edge after driving them. Pin changes pass through the two synchronizer flops, the STABLE_CYC filter, the selection flop and the output register. For each pin edge the bench therefore checks the outputs in the last cycle before the expected update and again in the cycle of the update. It uses STABLE_CYC+3 cycles for the fast direction and STABLE_CYC+DELAY_CYC+2 cycles for the slow one. Cancellation and short-glitch checks wait well past both windows to show that the outputs never moved.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;

    localparam int NIB_W        = 4;
    localparam int CODE_W       = 5;
    localparam int MV_W         = 11;
    localparam int BASE_MV      = 660;
    localparam int STEP_MV      = 20;
    localparam int NIB_OFS      = 4;
    localparam int DEFAULT_CODE = 7;
    localparam int MAX_CODE     = 19;

    typedef enum logic {
        SRC_TURBO  = 1'b0,
        SRC_MANUAL = 1'b1
    } src_mode_e;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } chan_cfg_t;

    typedef struct packed {
        src_mode_e mode;
        logic      tune_en;
        logic      dec_en;
        logic      sel_hi;
    } sel_ctrl_t;

    function automatic logic [CODE_W-1:0] nib_to_code(input logic [NIB_W-1:0] nib,
                                                      input logic dec);
        logic [CODE_W-1:0] r;
        if (dec && nib[3:2] == 2'b00)
            r = CODE_W'(3) - {3'b000, nib[1:0]};
        else
            r = {1'b0, nib} + CODE_W'(NIB_OFS);
        return r;
    endfunction

    function automatic logic [MV_W-1:0] code_to_mv(input logic [CODE_W-1:0] code);
        return MV_W'(BASE_MV) + MV_W'(STEP_MV) * {{(MV_W-CODE_W){1'b0}}, code};
    endfunction

endpackage

// File: rtl/refsel_pin_filter.sv
`timescale 1ns/1ps
module refsel_pin_filter #(
    parameter int STABLE_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_raw,
    output logic pin_clean
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q    <= '0;
            cnt_q     <= '0;
            pin_clean <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_raw};
            if (sync_q[1] == pin_clean) begin
                cnt_q <= '0;
            end else if (cnt_q == CW'(STABLE_CYC - 1)) begin
                pin_clean <= sync_q[1];
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/refsel_edge_delay.sv
`timescale 1ns/1ps
module refsel_edge_delay #(
    parameter int DELAY_CYC = 20000
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_clean,
    input  logic invert,
    output logic sel_hi
);
    localparam int DW = $clog2(DELAY_CYC + 1);

    logic [DW-1:0] dcnt_q;
    logic          fast_dir;

    // target level equal to ~invert is the fast direction
    assign fast_dir = (pin_clean != invert);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_hi <= 1'b0;
            dcnt_q <= '0;
        end else if (pin_clean == sel_hi) begin
            dcnt_q <= '0;                 // nothing pending, or reversal cancels
        end else if (fast_dir) begin
            sel_hi <= pin_clean;
            dcnt_q <= '0;
        end else if (dcnt_q == DW'(DELAY_CYC - 1)) begin
            sel_hi <= pin_clean;
            dcnt_q <= '0;
        end else begin
            dcnt_q <= dcnt_q + DW'(1);
        end
    end
endmodule

// File: rtl/refsel_chan_code.sv
`timescale 1ns/1ps
module refsel_chan_code
    import refsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  chan_cfg_t         cfg,
    input  sel_ctrl_t         ctl,
    output logic [CODE_W-1:0] code_q,
    output logic [MV_W-1:0]   mv_q
);
    logic [CODE_W-1:0] code_d;

    always_comb begin
        if (ctl.mode == SRC_MANUAL)
            code_d = nib_to_code(cfg.hi, ctl.dec_en);
        else if (!ctl.tune_en)
            code_d = CODE_W'(DEFAULT_CODE);
        else
            code_d = nib_to_code(ctl.sel_hi ? cfg.hi : cfg.lo, ctl.dec_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= CODE_W'(DEFAULT_CODE);
            mv_q   <= code_to_mv(CODE_W'(DEFAULT_CODE));
        end else begin
            code_q <= code_d;
            mv_q   <= code_to_mv(code_d);
        end
    end
endmodule

// File: rtl/turbo_ref_select.sv
`timescale 1ns/1ps
module turbo_ref_select
    import refsel_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int STABLE_CYC = 1000,
    parameter int DELAY_CYC  = 20000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  turbo_pin,
    input  logic                  mode_manual,
    input  logic                  turbo_en,
    input  logic                  turbo_inv,
    input  logic                  decrease_en,
    input  logic [8*NCH-1:0]      chan_cfg,
    output logic [CODE_W*NCH-1:0] ref_code,
    output logic [MV_W*NCH-1:0]   ref_mv
);
    localparam int CFG_W = 2 * NIB_W;

    logic      pin_clean;
    logic      sel_hi;
    sel_ctrl_t ctl;

    refsel_pin_filter #(.STABLE_CYC(STABLE_CYC)) u_filt (
        .clk(clk), .rst(rst), .pin_raw(turbo_pin), .pin_clean(pin_clean)
    );

    refsel_edge_delay #(.DELAY_CYC(DELAY_CYC)) u_dly (
        .clk(clk), .rst(rst), .pin_clean(pin_clean), .invert(turbo_inv), .sel_hi(sel_hi)
    );

    always_comb begin
        ctl.mode    = mode_manual ? SRC_MANUAL : SRC_TURBO;
        ctl.tune_en = turbo_en;
        ctl.dec_en  = decrease_en;
        ctl.sel_hi  = sel_hi;
    end

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        chan_cfg_t c_cfg;
        assign c_cfg = chan_cfg[CFG_W*ch +: CFG_W];
        refsel_chan_code u_code (
            .clk(clk), .rst(rst), .cfg(c_cfg), .ctl(ctl),
            .code_q(ref_code[CODE_W*ch +: CODE_W]),
            .mv_q(ref_mv[MV_W*ch +: MV_W])
        );
    end
endmodule

// File: rtl/refsel_checker.sv
`timescale 1ns/1ps
module refsel_checker #(
    parameter int NCH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_manual,
    input logic             turbo_en,
    input logic             decrease_en,
    input logic [8*NCH-1:0] chan_cfg,
    input logic [5*NCH-1:0] ref_code
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chk
        assert_code_range_R1: assert property (@(posedge clk) disable iff (rst)
            ref_code[5*ch +: 5] <= 5'd19);

        assert_manual_upper_R2: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mode_manual) && !$past(decrease_en))
            |-> ref_code[5*ch +: 5] == ({1'b0, $past(chan_cfg[8*ch+4 +: 4])} + 5'd4));

        assert_disabled_default_R3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(mode_manual) && !$past(turbo_en))
            |-> ref_code[5*ch +: 5] == 5'd7);

        assert_decrease_low_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(mode_manual) && $past(decrease_en)
             && $past(chan_cfg[8*ch+6 +: 2]) == 2'b00)
            |-> ref_code[5*ch +: 5] <= 5'd3);
    end
endmodule

bind turbo_ref_select refsel_checker #(.NCH(NCH)) u_chk (
    .clk(clk), .rst(rst), .mode_manual(mode_manual), .turbo_en(turbo_en),
    .decrease_en(decrease_en), .chan_cfg(chan_cfg), .ref_code(ref_code)
);

// File: tb/turbo_ref_select_test.sv
`timescale 1ns/1ps
module turbo_ref_select_test;
    localparam int NCH = 4;
    localparam int S   = 8;
    localparam int D   = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic turbo_pin = 1'b0, mode_manual = 1'b0, turbo_en = 1'b0;
    logic turbo_inv = 1'b0, decrease_en = 1'b0;
    logic [8*NCH-1:0]  chan_cfg = '0;
    logic [5*NCH-1:0]  ref_code;
    logic [11*NCH-1:0] ref_mv;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    turbo_ref_select #(.NCH(NCH), .STABLE_CYC(S), .DELAY_CYC(D)) uut (
        .clk(clk), .rst(rst), .turbo_pin(turbo_pin), .mode_manual(mode_manual),
        .turbo_en(turbo_en), .turbo_inv(turbo_inv), .decrease_en(decrease_en),
        .chan_cfg(chan_cfg), .ref_code(ref_code), .ref_mv(ref_mv)
    );

    typedef struct packed {
        logic        man;
        logic        en;
        logic        dec;
        logic [31:0] cfg;
        logic [43:0] mv;   // {ch3, ch2, ch1, ch0}, 11 bits each
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{1'b0, 1'b0, 1'b0, 32'h1234_5678, {11'd800, 11'd800, 11'd800, 11'd800}},
        '{1'b0, 1'b1, 1'b0, 32'h1234_5678, {11'd780, 11'd820, 11'd860, 11'd900}},
        '{1'b1, 1'b0, 1'b0, 32'h1234_5678, {11'd760, 11'd800, 11'd840, 11'd880}},
        '{1'b1, 1'b0, 1'b1, 32'h0F3A_2B1C, {11'd720, 11'd660, 11'd680, 11'd700}},
        '{1'b0, 1'b1, 1'b1, 32'h40F1_03A2, {11'd720, 11'd700, 11'd660, 11'd680}},
        '{1'b0, 1'b1, 1'b1, 32'hF48C_00FF, {11'd820, 11'd980, 11'd720, 11'd1040}},
        '{1'b0, 1'b0, 1'b1, 32'h0000_0000, {11'd800, 11'd800, 11'd800, 11'd800}},
        '{1'b1, 1'b1, 1'b0, 32'hF000_E10F, {11'd1040, 11'd740, 11'd1020, 11'd740}}
    };

    task automatic chk(input string tag, input logic [43:0] exp);
        for (int ch = 0; ch < NCH; ch++) begin
            logic [10:0] e_mv;
            logic [4:0]  e_code;
            e_mv   = exp[11*ch +: 11];
            e_code = 5'((e_mv - 11'd660) / 11'd20);
            checks++;
            if (ref_mv[11*ch +: 11] !== e_mv || ref_code[5*ch +: 5] !== e_code) begin
                errors++;
                $display("FAIL %s ch%0d: mv=%0d code=%0d expected mv=%0d code=%0d",
                         tag, ch, ref_mv[11*ch +: 11], ref_code[5*ch +: 5], e_mv, e_code);
            end
        end
    endtask

    function automatic logic [43:0] all_mv(input int v);
        return {11'(v), 11'(v), 11'(v), 11'(v)};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        turbo_pin = v;
    endtask

    initial begin
        // R9: reset state
        cyc(3);
        chk("R9 reset", all_mv(800));
        @(negedge clk) rst = 1'b0;
        cyc(2);
        chk("R9 after reset", all_mv(800));

        // R10 / R1 / R2 / R3 / R4: setting vectors, one edge latency
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            mode_manual = VECS[i].man;
            turbo_en    = VECS[i].en;
            decrease_en = VECS[i].dec;
            chan_cfg    = VECS[i].cfg;
            cyc(1);
            chk($sformatf("R10 R1 R2 R3 R4 vec%0d", i), VECS[i].mv);
        end

        // pin tests: upper nibble F (1040 mV), lower 0 (740 mV)
        @(negedge clk);
        mode_manual = 1'b0; turbo_en = 1'b1; decrease_en = 1'b0;
        turbo_inv = 1'b0; chan_cfg = 32'hF0F0_F0F0;
        cyc(2);
        chk("R5 start low", all_mv(740));

        // R5 rising immediate
        set_pin(1'b1);
        cyc(S + 3);
        chk("R5 rise before", all_mv(740));
        cyc(1);
        chk("R5 rise applied", all_mv(1040));

        // R5 falling delayed
        set_pin(1'b0);
        cyc(S + D + 2);
        chk("R5 fall before", all_mv(1040));
        cyc(1);
        chk("R5 fall applied", all_mv(740));

        // back high, then R7 cancel
        set_pin(1'b1);
        cyc(S + 10);
        chk("R5 high again", all_mv(1040));
        set_pin(1'b0);
        cyc(S + 10);
        set_pin(1'b1);
        cyc(S + D + 10);
        chk("R7 cancel", all_mv(1040));

        // R8 short glitch low ignored
        set_pin(1'b0);
        cyc(S / 2);
        set_pin(1'b1);
        cyc(S + D + 10);
        chk("R8 glitch", all_mv(1040));

        // R6 inverted: falling immediate, rising delayed
        @(negedge clk) turbo_inv = 1'b1;
        set_pin(1'b0);
        cyc(S + 3);
        chk("R6 fall before", all_mv(1040));
        cyc(1);
        chk("R6 fall applied", all_mv(740));
        set_pin(1'b1);
        cyc(S + D + 2);
        chk("R6 rise before", all_mv(740));
        cyc(1);
        chk("R6 rise applied", all_mv(1040));

        // R2 manual ignores pin
        @(negedge clk) begin mode_manual = 1'b1; chan_cfg = 32'h0F0F_0F0F; end
        cyc(1);
        chk("R2 manual", all_mv(740));
        set_pin(1'b0);
        cyc(S + D + 10);
        chk("R2 manual pin ignored", all_mv(740));

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule